// File: doc/BRIEF.md
# Four-Rail Power-Up Sequencer

This controller brings four supply rails up in a fixed order and then supervises them. Each rail has an external comparator that reports whether the rail is above its threshold as a one-bit flag. The controller drives three rail-enable outputs and one power-good output. Before power-good is reached, the first enable and power-good each wait out a qualification delay. The second and third enables follow their flags after synchronization only.

Once power-good is up, the controller supervises the rails. Loss of the first rail takes down everything and restarts the whole sequence. Loss of any other rail drops only power-good, and power-good must then qualify again with a fresh delay. The delay is a clock-cycle count set by a parameter, so a 190 ms window is simply that time multiplied by the clock rate. All flags pass through a synchronizer before any decision is made.

Top module: `rail_sequencer`

## Requirements
- R1: A synchronous active-high reset drives `railEn` and `powerGood` low on the next clock edge and returns the controller to the start of the sequence. After reset is released, the sequence restarts as in R2.
- R2: `railEn[0]` (the first enable) rises on the (DELAY_CYCLES+SYNC_STAGES+1)th rising edge after `railOk[0]` first goes high, provided the flag stays high throughout. It is low on all earlier edges.
- R3: With `railEn[0]` high, `railEn[1]` rises SYNC_STAGES+1 edges after `railOk[1]` goes high, with no delay count. `railEn[2]` follows `railOk[2]` the same way once `railEn[1]` is high.
- R4: Once `railEn[2]` is high, `powerGood` rises after `railOk[3:1]` have all been continuously high for DELAY_CYCLES edges following synchronization. That is DELAY_CYCLES+SYNC_STAGES+1 edges after the last of them rises.
- R5: While `powerGood` is high, a low `railOk[0]` drives all three enables and `powerGood` low SYNC_STAGES+1 edges after it falls. The full sequence, including both delays, then repeats.
- R6: While `powerGood` is high, a low flag on `railOk[1]`, `railOk[2]` or `railOk[3]` drops `powerGood` SYNC_STAGES+1 edges later and leaves all three enables high. `powerGood` returns only after R4's qualification runs again from zero.
- R7: Outputs assert strictly in order. `railEn[1]` rises only while `railEn[0]` is high, `railEn[2]` rises only while `railEn[1]` is high, and `powerGood` rises only while `railEn[2]` is high.
- R8: If the qualifying flag falls during a delay count, the count restarts from zero when the flag returns.
- R9: Before `powerGood` is reached, a low `railOk[0]` at any stage after the first enable drops every enable. It does so SYNC_STAGES+1 edges after the flag falls, and the sequence restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| railOk | input | 4 | Comparator flags; bit 0 is the first rail, bit 3 the last |
| railEn | output | 3 | Rail enables; bit 0 is the first enable |
| powerGood | output | 1 | All rails qualified |

## Verification
A corrupted sequence state shows up at once as an enable pattern that breaks the order, or as an output that rises early. Either is visible on the edge after the state changes. A wrong delay counter shows up as an edge of `railEn[0]` or `powerGood` one or more cycles away from DELAY_CYCLES+3 in the bench's default configuration. So each qualification is sampled on the edge before and the edge of the expected rise. A supervision fault that is routed to the wrong outputs shows up three edges after the flag falls, as enables that stay up or enables that drop when they should stay.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  localparam int RAIL_COUNT = 4;

  typedef enum logic [2:0] {
    ST_QUAL_FIRST  = 3'd0,
    ST_WAIT_SECOND = 3'd1,
    ST_WAIT_THIRD  = 3'd2,
    ST_QUAL_GOOD   = 3'd3,
    ST_MONITOR     = 3'd4
  } seqState_t;

  typedef struct packed {
    logic clear;
    logic run;
  } timerCmd_t;

endpackage

// File: rtl/rail_seq_datapath.sv
module rail_seq_datapath
  import rail_seq_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int DELAY_CYCLES = 19_000_000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [RAIL_COUNT-1:0] railRaw,
  input  timerCmd_t             timerCmd,
  output logic [RAIL_COUNT-1:0] railSync,
  output logic                  delayDone
);

  localparam int CNT_W = $clog2(DELAY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(DELAY_CYCLES);

  logic [RAIL_COUNT-1:0] syncPipe [SYNC_STAGES];
  logic [CNT_W-1:0]      delayCnt;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) syncPipe[s] <= '0;
        else     syncPipe[s] <= railRaw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) syncPipe[s] <= '0;
        else     syncPipe[s] <= syncPipe[s-1];
      end
    end
  end

  assign railSync  = syncPipe[SYNC_STAGES-1];
  assign delayDone = (delayCnt == CNT_LIMIT);

  always_ff @(posedge clk) begin
    if (rst || timerCmd.clear) delayCnt <= '0;
    else if (timerCmd.run && !delayDone) delayCnt <= delayCnt + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    delayCnt <= CNT_LIMIT); // R2
  AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    timerCmd.clear |=> (delayCnt == '0)); // R8
  AST_RUN_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (timerCmd.run && !timerCmd.clear && !delayDone) |=> (delayCnt == $past(delayCnt) + 1'b1)); // R8

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [RAIL_COUNT-1:0] railSync,
  input  logic                  delayDone,
  output timerCmd_t             timerCmd,
  output logic [2:0]            railEn,
  output logic                  powerGood
);

  seqState_t state, nextState;
  logic      firstOk, laterOk;

  assign firstOk = railSync[0];
  assign laterOk = &railSync[RAIL_COUNT-1:1];

  always_ff @(posedge clk) begin
    if (rst) state <= ST_QUAL_FIRST;
    else     state <= nextState;
  end

  always_comb begin
    nextState      = state;
    timerCmd.clear = 1'b1;
    timerCmd.run   = 1'b0;
    case (state)
      ST_QUAL_FIRST: begin
        timerCmd.clear = !firstOk;
        timerCmd.run   = firstOk;
        if (firstOk && delayDone) nextState = ST_WAIT_SECOND;
      end
      ST_WAIT_SECOND: begin
        if (!firstOk)         nextState = ST_QUAL_FIRST;
        else if (railSync[1]) nextState = ST_WAIT_THIRD;
      end
      ST_WAIT_THIRD: begin
        if (!firstOk)         nextState = ST_QUAL_FIRST;
        else if (railSync[2]) nextState = ST_QUAL_GOOD;
      end
      ST_QUAL_GOOD: begin
        if (!firstOk) begin
          nextState = ST_QUAL_FIRST;
        end else begin
          timerCmd.clear = !laterOk;
          timerCmd.run   = laterOk;
          if (laterOk && delayDone) nextState = ST_MONITOR;
        end
      end
      ST_MONITOR: begin
        if (!firstOk)      nextState = ST_QUAL_FIRST;
        else if (!laterOk) nextState = ST_QUAL_GOOD;
      end
      default: nextState = ST_QUAL_FIRST;
    endcase
  end

  assign railEn[0] = (state != ST_QUAL_FIRST);
  assign railEn[1] = (state == ST_WAIT_THIRD) || (state == ST_QUAL_GOOD) || (state == ST_MONITOR);
  assign railEn[2] = (state == ST_QUAL_GOOD) || (state == ST_MONITOR);
  assign powerGood = (state == ST_MONITOR);

  AST_RESET_LOW: assert property (@(posedge clk)
    $past(rst) |-> (railEn == 3'b000 && !powerGood)); // R1
  AST_FIRST_NEEDS_DELAY: assert property (@(posedge clk) disable iff (rst)
    $rose(railEn[0]) |-> ($past(delayDone) && $past(firstOk))); // R2
  AST_GOOD_NEEDS_DELAY: assert property (@(posedge clk) disable iff (rst)
    $rose(powerGood) |-> ($past(delayDone) && $past(laterOk))); // R4
  AST_FIRST_LOSS: assert property (@(posedge clk) disable iff (rst)
    (railEn[0] && !firstOk) |=> (railEn == 3'b000 && !powerGood)); // R5
  AST_LATER_LOSS: assert property (@(posedge clk) disable iff (rst)
    (powerGood && firstOk && !laterOk) |=> (!powerGood && railEn == 3'b111)); // R6
  AST_ORDER_SECOND: assert property (@(posedge clk) disable iff (rst)
    $rose(railEn[1]) |-> $past(railEn[0])); // R7
  AST_ORDER_THIRD: assert property (@(posedge clk) disable iff (rst)
    $rose(railEn[2]) |-> $past(railEn[1])); // R7
  AST_ORDER_GOOD: assert property (@(posedge clk) disable iff (rst)
    $rose(powerGood) |-> $past(railEn[2])); // R7

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rail_seq_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int DELAY_CYCLES = 19_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] railOk,
  output logic [2:0] railEn,
  output logic       powerGood
);

  logic [RAIL_COUNT-1:0] railSync;
  logic                  delayDone;
  timerCmd_t             timerCmd;

  rail_seq_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .DELAY_CYCLES(DELAY_CYCLES)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .railRaw  (railOk),
    .timerCmd (timerCmd),
    .railSync (railSync),
    .delayDone(delayDone)
  );

  rail_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .railSync (railSync),
    .delayDone(delayDone),
    .timerCmd (timerCmd),
    .railEn   (railEn),
    .powerGood(powerGood)
  );

endmodule

// File: tb/rail_sequencer_bench.sv
module rail_sequencer_bench;

  localparam int DELAY = 16;
  localparam int LAT   = DELAY + 3;
  localparam int NVEC  = 23;

  // {rails[3:0], edges[7:0], expected {pg,en3,en2,en1}[3:0], requirement[3:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    {4'b0001, 8'd10,      4'b0000, 4'd8},  // R8 partial count
    {4'b0000, 8'd4,       4'b0000, 4'd8},  // R8 drop clears
    {4'b0001, 8'(LAT-1),  4'b0000, 4'd8},  // R8 count restarted
    {4'b0001, 8'd1,       4'b0001, 4'd2},  // R2 exact edge
    {4'b0011, 8'd2,       4'b0001, 4'd3},  // R3 not yet
    {4'b0011, 8'd1,       4'b0011, 4'd3},  // R3 no delay
    {4'b0111, 8'd3,       4'b0111, 4'd3},  // R3 third enable
    {4'b1111, 8'(LAT-1),  4'b0111, 4'd4},  // R4 one edge early
    {4'b1111, 8'd1,       4'b1111, 4'd4},  // R4 exact edge
    {4'b1011, 8'd2,       4'b1111, 4'd6},  // R6 not yet seen
    {4'b1011, 8'd1,       4'b0111, 4'd6},  // R6 pg drops, enables held
    {4'b1111, 8'(LAT-1),  4'b0111, 4'd6},  // R6 requalify from zero
    {4'b1111, 8'd1,       4'b1111, 4'd6},
    {4'b1110, 8'd3,       4'b0000, 4'd5},  // R5 first rail loss
    {4'b1111, 8'(LAT),    4'b0001, 4'd7},  // R7 first
    {4'b1111, 8'd1,       4'b0011, 4'd7},  // R7 second
    {4'b1111, 8'd1,       4'b0111, 4'd7},  // R7 third
    {4'b1111, 8'(DELAY),  4'b0111, 4'd7},  // R7 pg waits
    {4'b1111, 8'd1,       4'b1111, 4'd7},  // R7 pg last
    {4'b1110, 8'd3,       4'b0000, 4'd5},  // R5 again
    {4'b1111, 8'(LAT+2),  4'b0111, 4'd9},  // R9 reach third enable
    {4'b1110, 8'd3,       4'b0000, 4'd9},  // R9 loss before pg
    {4'b1111, 8'(LAT-1),  4'b0000, 4'd9}   // R9 full restart, delay again
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] railOk = 4'b0000;
  logic [2:0] railEn;
  logic       powerGood;
  int         nTests = 0;
  int         nFail = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  rail_sequencer #(.SYNC_STAGES(2), .DELAY_CYCLES(DELAY)) u_rail_sequencer (
    .clk      (clk),
    .rst      (rst),
    .railOk   (railOk),
    .railEn   (railEn),
    .powerGood(powerGood)
  );

  task automatic checkOut(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {powerGood, railEn};
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("[TB] FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic stepEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      nTests++;
      nFail++;
      $display("[TB] FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    stepEdges(3);
    checkOut("R1 reset state", 4'b0000);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      railOk = VEC[i][19:16];
      stepEdges(int'(VEC[i][15:8]));
      checkOut($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][7:4]);
    end

    // Full bring-up, then reset mid-operation
    railOk = 4'b1111;
    stepEdges(2 * LAT);
    checkOut("R7 full bring-up", 4'b1111);
    rst = 1'b1;
    stepEdges(1);
    checkOut("R1 reset clears outputs", 4'b0000);
    rst = 1'b0;
    stepEdges(LAT - 1);
    checkOut("R1 sequence restarts after reset", 4'b0000);
    stepEdges(1);
    checkOut("R2 first enable after reset", 4'b0001);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule